// File: doc/BRIEF.md
# Ethernet Controller Command and Interrupt Register Block

This block is the byte-wide register front end of a small Ethernet controller. Software writes a control byte whose command bits are acted on only when they go from 0 to 1. Each such transition produces a one-cycle pulse toward the receive engine, the transmit engine or the controller's internal reset. Completion events from the receive and transmit engines are gated by a mask register and latched in a status register. Software clears that register by writing ones. The OR of all enabled status bits drives a level interrupt line.

A second control byte selects how many stored frames it takes to raise one receive interrupt. A pair of link registers models negotiation: any write that asks for negotiation reports a fixed link result at once. The packet buffers, the data path and the PHY sit outside this block. They connect only through the event and pulse pins.

Top module: `netctl_regs`

## Requirements
- R1: After a synchronous active-low reset, the registers read as follows: control A at 0x00 reads 0x00, control B at 0x01 reads 0x00, mask at 0x08 reads 0x00, status at 0x09 reads 0x00, link config at 0x30 reads 0x84 and link status at 0x31 reads 0x00. The interrupt and all pulse outputs are low.
- R2: Control A, control B, mask and link config read back the last byte written to them. Any unmapped address reads 0x00.
- R3: In control A, bit 3 is start-receive and bit 0 is reset. A write that takes one of these bits from 0 to 1 gives a one-cycle `rx_start_pulse` or `soft_rst_pulse`, visible in the cycle after the write. A write that leaves the bit at 1 gives no pulse.
- R4: Control A bit 2 is start-transmit. A 0-to-1 write of this bit pulses `tx_start_pulse` for one cycle when `tx_loaded` is high. When `tx_loaded` is low, no pulse occurs and status bit 4 (0x10, transmit error) is set instead.
- R5: Writing a byte to status at 0x09 clears each bit written as 1 and leaves every other bit as it was.
- R6: A `tx_done` event sets status bit 2 (0x04) only when mask bit 2 is set.
- R7: Control B bits [7:6] = n select 2^n receive events per interrupt (1, 2, 4 or 8). Status bit 1 (0x02) is set on the event that completes the count, provided mask bit 1 is set. The count then restarts.
- R8: A `rx_done` event while control A bit 3 is still set re-arms reception with a one-cycle `rx_start_pulse` in the next cycle.
- R9: `irq` is high exactly when some status bit is set together with its mask bit. It follows the status register one cycle later.
- R10: A write to link config containing bit 2 (0x04, negotiate) or bit 3 (0x08, restart) makes link status read 0x05 (link up, full duplex, 10 Mbit). Other config writes leave link status unchanged. Link status ignores writes.
- R11: When an event sets a status bit in the same cycle that software clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| rx_done | input | 1 | One-cycle pulse: a received frame has been stored |
| tx_done | input | 1 | One-cycle pulse: a transmission finished |
| tx_loaded | input | 1 | A transmit frame is ready |
| soft_rst_pulse | output | 1 | Controller reset command |
| rx_start_pulse | output | 1 | Start or re-arm reception |
| tx_start_pulse | output | 1 | Start transmission |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit address and a coalescing limit of 2^3. With these values every mapped offset can be addressed, and all four receive-per-interrupt settings, up to eight events, are reached in short event bursts. The runs cover the count boundaries one event short of each threshold and exactly at it. They also cover the clear that collides with a set, and a second reset that shows the link result comes only from a negotiation write.

// File: rtl/netctl_pkg.sv
// Shared constants for the network command and interrupt register block.
// Assumes byte-wide registers; offsets are fixed by the software map.
package netctl_pkg;
    localparam int BYTE_W      = 8;
    // register offsets
    localparam int OFF_CTRL_A  = 'h00;
    localparam int OFF_CTRL_B  = 'h01;
    localparam int OFF_MASK    = 'h08;
    localparam int OFF_STAT    = 'h09;
    localparam int OFF_LCFG    = 'h30;
    localparam int OFF_LSTAT   = 'h31;
    // control A command bit positions
    localparam int CA_RESET    = 0;
    localparam int CA_TX_GO    = 2;
    localparam int CA_RX_GO    = 3;
    // control B receive count field
    localparam int CB_CNT_LSB  = 6;
    localparam int CB_CNT_W    = 2;
    // status / mask bit positions
    localparam int EV_RX       = 1;
    localparam int EV_TX       = 2;
    localparam int EV_TX_ERR   = 4;
    // link registers
    localparam logic [BYTE_W-1:0] LCFG_RESET = 8'h84;
    localparam logic [BYTE_W-1:0] LCFG_NEG   = 8'h0C;
    localparam logic [BYTE_W-1:0] LINK_10FD  = 8'h05;
endpackage

// File: rtl/netctl_ctrl.sv
// Control A / control B registers and command pulse generation.
// Commands fire on 0-to-1 transitions against the stored control A value.
// Assumes write enables are single-cycle strobes already decoded.
module netctl_ctrl
    import netctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_done,
    input  logic              tx_loaded,
    output logic [BYTE_W-1:0] ctrl_a,
    output logic [BYTE_W-1:0] ctrl_b,
    output logic              tx_reject,
    output logic              soft_rst_pulse,
    output logic              rx_start_pulse,
    output logic              tx_start_pulse
);
    logic [BYTE_W-1:0] rise;

    // Bits that this write takes from 0 to 1.
    always_comb begin
        rise = wr_a ? (wdata & ~ctrl_a) : '0;
    end

    // A transmit command without a loaded frame is rejected.
    assign tx_reject = rise[CA_TX_GO] & ~tx_loaded;

    // Store the control bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a <= '0;
            ctrl_b <= '0;
        end else begin
            if (wr_a) ctrl_a <= wdata;
            if (wr_b) ctrl_b <= wdata;
        end
    end

    // Register the one-cycle command pulses, including receive re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_rst_pulse <= 1'b0;
            rx_start_pulse <= 1'b0;
            tx_start_pulse <= 1'b0;
        end else begin
            soft_rst_pulse <= rise[CA_RESET];
            rx_start_pulse <= rise[CA_RX_GO] | (rx_done & ctrl_a[CA_RX_GO]);
            tx_start_pulse <= rise[CA_TX_GO] & tx_loaded;
        end
    end

    // R4
    tx_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_pulse |-> $past(tx_loaded));
    // R3
    tx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_pulse |=> !tx_start_pulse);
    // R3
    rst_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> !soft_rst_pulse);
endmodule

// File: rtl/netctl_irq.sv
// Interrupt mask, write-one-to-clear status, receive event coalescing
// and the registered interrupt line. A set from an event wins over a
// clear in the same cycle. Assumes event inputs are one-cycle pulses.
module netctl_irq
    import netctl_pkg::*;
#(
    parameter int COAL_LOG_MAX = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_mask,
    input  logic                wr_stat,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                rx_done,
    input  logic                tx_done,
    input  logic                tx_reject,
    input  logic [CB_CNT_W-1:0] rx_sel,
    output logic [BYTE_W-1:0]   mask,
    output logic [BYTE_W-1:0]   status,
    output logic                irq
);
    localparam int CNT_W = COAL_LOG_MAX + 1;

    logic [CNT_W-1:0]  rx_cnt;
    logic [CNT_W-1:0]  rx_thr;
    logic [CNT_W-1:0]  rx_next;
    logic              rx_hit;
    logic [BYTE_W-1:0] set_vec;
    logic [BYTE_W-1:0] clr_vec;

    // Threshold and hit detection for the receive count.
    always_comb begin
        rx_thr  = CNT_W'(1) << rx_sel;
        rx_next = rx_cnt + CNT_W'(1);
        rx_hit  = rx_done && (rx_next >= rx_thr);
    end

    // Per-bit set sources and software clear vector.
    always_comb begin
        set_vec            = '0;
        set_vec[EV_RX]     = rx_hit & mask[EV_RX];
        set_vec[EV_TX]     = tx_done & mask[EV_TX];
        set_vec[EV_TX_ERR] = tx_reject;
        clr_vec            = wr_stat ? wdata : '0;
    end

    // Count received frames toward the selected threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_cnt <= '0;
        else if (rx_hit) rx_cnt <= '0;
        else if (rx_done) rx_cnt <= rx_next;
    end

    // Mask register, status register and interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            status <= '0;
            irq    <= 1'b0;
        end else begin
            if (wr_mask) mask <= wdata;
            status <= (status & ~clr_vec) | set_vec;
            irq    <= |(status & mask);
        end
    end

    // R6
    tx_set_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[EV_TX]) |-> $past(mask[EV_TX]));
    // R7
    rx_set_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[EV_RX]) |-> ($past(mask[EV_RX]) && $past(rx_done)));
    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !rx_done && !tx_done && !tx_reject) |=> ((status & $past(wdata)) == '0));
    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(status & mask)));
endmodule

// File: rtl/netctl_link.sv
// Link negotiation config and status. A negotiation or restart request
// reports a fixed 10 Mbit full-duplex link immediately. Status is read-only.
module netctl_link
    import netctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lcfg,
    output logic [BYTE_W-1:0] lstat
);
    // Store config and publish the link result on a negotiation request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcfg  <= LCFG_RESET;
            lstat <= '0;
        end else if (wr_cfg) begin
            lcfg <= wdata;
            if (|(wdata & LCFG_NEG)) lstat <= LINK_10FD;
        end
    end

    // R10
    lstat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lstat) |-> $past(wr_cfg && (|(wdata & LCFG_NEG))));
endmodule

// File: rtl/netctl_regs.sv
// Top of the network command and interrupt register block: address
// decode, read mux and the three register groups. Reads are combinational.
module netctl_regs
    import netctl_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int COAL_LOG_MAX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              rx_done,
    input  logic              tx_done,
    input  logic              tx_loaded,
    output logic              soft_rst_pulse,
    output logic              rx_start_pulse,
    output logic              tx_start_pulse,
    output logic              irq
);
    logic              wr_a, wr_b, wr_mask, wr_stat, wr_cfg;
    logic              tx_reject;
    logic [BYTE_W-1:0] ctrl_a, ctrl_b, mask, status, lcfg, lstat;

    // Decode the write strobe per register.
    always_comb begin
        wr_a    = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL_A));
        wr_b    = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL_B));
        wr_mask = reg_wr && (reg_addr == ADDR_W'(OFF_MASK));
        wr_stat = reg_wr && (reg_addr == ADDR_W'(OFF_STAT));
        wr_cfg  = reg_wr && (reg_addr == ADDR_W'(OFF_LCFG));
    end

    netctl_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_a           (wr_a),
        .wr_b           (wr_b),
        .wdata          (reg_wdata),
        .rx_done        (rx_done),
        .tx_loaded      (tx_loaded),
        .ctrl_a         (ctrl_a),
        .ctrl_b         (ctrl_b),
        .tx_reject      (tx_reject),
        .soft_rst_pulse (soft_rst_pulse),
        .rx_start_pulse (rx_start_pulse),
        .tx_start_pulse (tx_start_pulse)
    );

    netctl_irq #(.COAL_LOG_MAX(COAL_LOG_MAX)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask   (wr_mask),
        .wr_stat   (wr_stat),
        .wdata     (reg_wdata),
        .rx_done   (rx_done),
        .tx_done   (tx_done),
        .tx_reject (tx_reject),
        .rx_sel    (ctrl_b[CB_CNT_LSB +: CB_CNT_W]),
        .mask      (mask),
        .status    (status),
        .irq       (irq)
    );

    netctl_link u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cfg (wr_cfg),
        .wdata  (reg_wdata),
        .lcfg   (lcfg),
        .lstat  (lstat)
    );

    // Read mux; unmapped addresses return zero.
    always_comb begin
        if      (reg_addr == ADDR_W'(OFF_CTRL_A)) reg_rdata = ctrl_a;
        else if (reg_addr == ADDR_W'(OFF_CTRL_B)) reg_rdata = ctrl_b;
        else if (reg_addr == ADDR_W'(OFF_MASK))   reg_rdata = mask;
        else if (reg_addr == ADDR_W'(OFF_STAT))   reg_rdata = status;
        else if (reg_addr == ADDR_W'(OFF_LCFG))   reg_rdata = lcfg;
        else if (reg_addr == ADDR_W'(OFF_LSTAT))  reg_rdata = lstat;
        else                                      reg_rdata = '0;
    end
endmodule

// File: tb/test_netctl_regs.sv
`timescale 1ns/1ps
module test_netctl_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_rdata;
    logic       rx_done = 1'b0, tx_done = 1'b0, tx_loaded = 1'b0;
    logic       soft_rst_pulse, rx_start_pulse, tx_start_pulse, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // expectation queues: requirement, source (0 read data, 1 signals), value
    string      rq[$];
    int         sq[$];
    logic [7:0] eq[$];

    always #2.5 clk = ~clk;

    netctl_regs i_netctl_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .rx_done(rx_done),
        .tx_done(tx_done), .tx_loaded(tx_loaded), .soft_rst_pulse(soft_rst_pulse),
        .rx_start_pulse(rx_start_pulse), .tx_start_pulse(tx_start_pulse), .irq(irq)
    );

    // Monitor: pops expectations shortly after each falling edge.
    initial forever begin
        string      r;
        int         s;
        logic [7:0] e;
        logic [7:0] a;
        @(negedge clk);
        #1;
        while (rq.size() > 0) begin
            r = rq.pop_front();
            s = sq.pop_front();
            e = eq.pop_front();
            a = (s == 0) ? reg_rdata
                         : {4'b0, irq, soft_rst_pulse, rx_start_pulse, tx_start_pulse};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: actual 0x%02h expected 0x%02h", r, a, e);
            end
        end
    end

    task automatic push(string r, int s, logic [7:0] e);
        rq.push_back(r); sq.push_back(s); eq.push_back(e);
    endtask

    // signal byte = {irq, soft_rst_pulse, rx_start_pulse, tx_start_pulse}
    task automatic chk_sig(string r, logic [7:0] e);
        push(r, 1, e);
    endtask

    task automatic chk_rd(string r, logic [7:0] a, logic [7:0] e);
        @(negedge clk);
        reg_addr = a;
        push(r, 0, e);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ev(bit rx, bit tx, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_done = rx; tx_done = tx;
            @(negedge clk);
            rx_done = 1'b0; tx_done = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk_sig("R1", 8'h00);
        chk_rd("R1", 8'h00, 8'h00);
        chk_rd("R1", 8'h01, 8'h00);
        chk_rd("R1", 8'h08, 8'h00);
        chk_rd("R1", 8'h09, 8'h00);
        chk_rd("R1", 8'h30, 8'h84);
        chk_rd("R1", 8'h31, 8'h00);
        // R2 readback and unmapped read
        wr(8'h01, 8'h15); chk_rd("R2", 8'h01, 8'h15);
        wr(8'h08, 8'hA5); chk_rd("R2", 8'h08, 8'hA5);
        wr(8'h08, 8'h00);
        wr(8'h30, 8'h80); chk_rd("R2", 8'h30, 8'h80);
        chk_rd("R10", 8'h31, 8'h00);
        chk_rd("R2", 8'h05, 8'h00);
        wr(8'h01, 8'h00);
        // R3 rising-edge commands
        wr(8'h00, 8'h08); chk_sig("R3", 8'h02);
        @(negedge clk);   chk_sig("R3", 8'h00);
        wr(8'h00, 8'h08); chk_sig("R3", 8'h00);
        wr(8'h00, 8'h09); chk_sig("R3", 8'h04);
        chk_rd("R2", 8'h00, 8'h09);
        wr(8'h00, 8'h00);
        // R4 transmit start with and without a frame
        tx_loaded = 1'b1;
        wr(8'h00, 8'h04); chk_sig("R4", 8'h01);
        wr(8'h00, 8'h00);
        tx_loaded = 1'b0;
        wr(8'h00, 8'h04); chk_sig("R4", 8'h00);
        chk_rd("R4", 8'h09, 8'h10);
        wr(8'h00, 8'h00);
        wr(8'h09, 8'h10); chk_rd("R5", 8'h09, 8'h00);
        // R6 / R9 masked transmit event and interrupt lag
        wr(8'h08, 8'h06);
        ev(1'b0, 1'b1, 1);
        chk_sig("R9", 8'h00);
        @(negedge clk); chk_sig("R9", 8'h08);
        chk_rd("R6", 8'h09, 8'h04);
        // R5 partial clears
        wr(8'h00, 8'h04); wr(8'h00, 8'h00);
        chk_rd("R5", 8'h09, 8'h14);
        wr(8'h09, 8'hEF); chk_rd("R5", 8'h09, 8'h10);
        wr(8'h09, 8'h10); chk_rd("R5", 8'h09, 8'h00);
        chk_sig("R9", 8'h00);
        // R6 unmasked transmit event is dropped
        wr(8'h08, 8'h02);
        ev(1'b0, 1'b1, 1); chk_rd("R6", 8'h09, 8'h00);
        // R7 receive coalescing
        ev(1'b1, 1'b0, 1); chk_rd("R7", 8'h09, 8'h02);
        wr(8'h09, 8'h02);
        wr(8'h01, 8'h80);
        ev(1'b1, 1'b0, 3); chk_rd("R7", 8'h09, 8'h00);
        ev(1'b1, 1'b0, 1); chk_rd("R7", 8'h09, 8'h02);
        wr(8'h09, 8'h02);
        wr(8'h01, 8'hC0);
        ev(1'b1, 1'b0, 7); chk_rd("R7", 8'h09, 8'h00);
        ev(1'b1, 1'b0, 1); chk_rd("R7", 8'h09, 8'h02);
        wr(8'h09, 8'h02);
        wr(8'h01, 8'h40);
        ev(1'b1, 1'b0, 1); chk_rd("R7", 8'h09, 8'h00);
        ev(1'b1, 1'b0, 1); chk_rd("R7", 8'h09, 8'h02);
        wr(8'h09, 8'h02);
        wr(8'h08, 8'h00); wr(8'h01, 8'h00);
        ev(1'b1, 1'b0, 1); chk_rd("R7", 8'h09, 8'h00);
        // R8 receive re-arm
        wr(8'h00, 8'h08);
        ev(1'b1, 1'b0, 1); chk_sig("R8", 8'h02);
        wr(8'h00, 8'h00);
        ev(1'b1, 1'b0, 1); chk_sig("R8", 8'h00);
        // R11 set wins over clear
        wr(8'h08, 8'h04);
        ev(1'b0, 1'b1, 1);
        @(negedge clk);
        reg_addr = 8'h09; reg_wdata = 8'h04; reg_wr = 1'b1; tx_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tx_done = 1'b0;
        chk_rd("R11", 8'h09, 8'h04);
        wr(8'h09, 8'h04); chk_rd("R5", 8'h09, 8'h00);
        // R10 link negotiation
        wr(8'h31, 8'hFF); chk_rd("R10", 8'h31, 8'h00);
        wr(8'h30, 8'h04); chk_rd("R10", 8'h31, 8'h05);
        wr(8'h30, 8'h80); chk_rd("R10", 8'h31, 8'h05);
        wr(8'h31, 8'h00); chk_rd("R10", 8'h31, 8'h05);
        do_reset();
        chk_rd("R1", 8'h31, 8'h00);
        wr(8'h30, 8'h08); chk_rd("R10", 8'h31, 8'h05);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        finish_run();
    end
endmodule